// File: doc/BRIEF.md
# Channel Period Timer with Step Sequencer

This block divides a system-rate clock enable by a programmable period and advances a small step counter each time the division wraps. A sound-generator channel uses it as the pitch source. The period comes from two fields: a low byte and a narrow high field. Each time the countdown wraps, the step counter moves on, and a waveform stage outside this block can use it as an index.

A mode input picks one of two ways to use the period. In direct mode the countdown reloads with the period itself. In doubled mode it reloads with the period shifted up one place and its lowest bit forced to one. The cycle that performs the reload does not also count, so the doubled period is 2*(P+1) enabled cycles and no adder is needed. The countdown never goes below zero, so the wrap is always taken at zero and nothing overflows.

A period written while the timer runs does not disturb the countdown in progress. The new value is read only when the next reload happens. A synchronous reset clears the count and the step to zero, so the first enabled cycle after reset performs a reload.

Top module: `chan_period_timer`

## Requirements
- R1: The period P is the high field concatenated above the low field ({per_hi, per_lo}), giving an 11-bit value with default widths.
- R2: In doubled mode (dbl_mode = 1) the value loaded into the count is {P, 1'b1}, so the count is one bit wider than P.
- R3: On an enabled cycle with a nonzero count, the count decreases by exactly one.
- R4: On an enabled cycle with a zero count, the count takes the reload value and does not decrement in that cycle.
- R5: In doubled mode, ticks are 2*P+2 enabled cycles apart. For example, P = 10 loads 21 and ticks every 22 cycles.
- R6: In direct mode (dbl_mode = 0) the reload value is P and ticks are P+1 enabled cycles apart. For example, P = 4 counts 4,3,2,1,0.
- R7: The step output increases by one, modulo 8, on every reload and changes at no other time.
- R8: The largest period in doubled mode loads an all-ones count and still wraps only at zero, with no overflow and no underflow.
- R9: A period change while counting leaves the running countdown untouched. The new value is used from the next reload on.
- R10: Synchronous reset sets count and step to zero, and the first enabled cycle after reset reloads and ticks.
- R11: tick is high during exactly the enabled cycle in which the reload happens (combinational on the current count and ce).
- R12: While ce is low, count and step hold and tick stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable at the system rate |
| per_lo | input | LO_W (8) | Low field of the period |
| per_hi | input | HI_W (3) | High field of the period |
| dbl_mode | input | 1 | 1 = doubled period, 0 = direct period |
| count | output | LO_W+HI_W+1 (12) | Current countdown value |
| tick | output | 1 | High in the enabled cycle that reloads the count |
| step | output | SEQ_W (3) | Sequencer step |

## Verification
The bench builds the timer with a 4-bit low field and a 2-bit high field, so the period space holds only 64 values. It sweeps every one of them in both modes and checks the count, the tick and the step on every cycle against an arithmetic model, together with the spacing between ticks. The small build puts the largest period, whose doubled load is an all-ones 7-bit count, within reach of the same sweep. Further runs cover gaps in the enable, a period change partway through a countdown, the step wrapping past seven, and a reset in the middle of a run.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic {
        MODE_DIRECT  = 1'b0,
        MODE_DOUBLED = 1'b1
    } ptmr_mode_e;

endpackage

// File: rtl/ptmr_reload.sv
module ptmr_reload #(
    parameter int PER_W = 11,
    localparam int CNT_W = PER_W + 1
) (
    input  logic [PER_W-1:0]      period,
    input  ptmr_pkg::ptmr_mode_e  mode,
    output logic [CNT_W-1:0]      load_val
);

    // Doubled: shift up and force the LSB (OR, no adder). Direct: zero-extend.
    always_comb begin
        if (mode == ptmr_pkg::MODE_DOUBLED) begin
            load_val = {period, 1'b1};
        end else begin
            load_val = {1'b0, period};
        end
    end

endmodule

// File: rtl/ptmr_down.sv
module ptmr_down #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             ce,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } down_st_t;

    down_st_t st_d, st_q;
    logic     at_zero;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.cnt == '0);
        wrap    = ce & at_zero;
        if (ce) begin
            if (at_zero) begin
                st_d.cnt = load_val;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    // R3: enabled nonzero count steps down by one
    a_r3_decrement: assert property (@(posedge clk) disable iff (srst)
        (ce && count != '0) |=> (count == $past(count) - CNT_W'(1)));

    // R4: enabled zero count takes the reload value
    a_r4_reload: assert property (@(posedge clk) disable iff (srst)
        wrap |=> (count == $past(load_val)));

    // R12: no enable, no movement
    a_r12_hold: assert property (@(posedge clk) disable iff (srst)
        !ce |=> $stable(count));

endmodule

// File: rtl/ptmr_seq.sv
module ptmr_seq #(
    parameter int SEQ_W = 3
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             adv,
    output logic [SEQ_W-1:0] step
);

    typedef struct packed {
        logic [SEQ_W-1:0] pos;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.pos = st_q.pos + SEQ_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step = st_q.pos;

    // R7: each reload advances the step, wrapping naturally
    a_r7_advance: assert property (@(posedge clk) disable iff (srst)
        adv |=> (step == $past(step) + SEQ_W'(1)));

    // R7: step changes only on a reload
    a_r7_hold: assert property (@(posedge clk) disable iff (srst)
        !adv |=> $stable(step));

endmodule

// File: rtl/chan_period_timer.sv
module chan_period_timer #(
    parameter int LO_W  = 8,
    parameter int HI_W  = 3,
    parameter int SEQ_W = 3,
    localparam int PER_W = LO_W + HI_W,
    localparam int CNT_W = PER_W + 1
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             ce,
    input  logic [LO_W-1:0]  per_lo,
    input  logic [HI_W-1:0]  per_hi,
    input  logic             dbl_mode,
    output logic [CNT_W-1:0] count,
    output logic             tick,
    output logic [SEQ_W-1:0] step
);

    logic [PER_W-1:0] period;
    logic [CNT_W-1:0] load_val;
    ptmr_pkg::ptmr_mode_e mode;

    assign period = {per_hi, per_lo};
    assign mode   = ptmr_pkg::ptmr_mode_e'(dbl_mode);

    ptmr_reload #(.PER_W(PER_W)) u_reload (
        .period   (period),
        .mode     (mode),
        .load_val (load_val)
    );

    ptmr_down #(.CNT_W(CNT_W)) u_down (
        .clk      (clk),
        .srst     (srst),
        .ce       (ce),
        .load_val (load_val),
        .count    (count),
        .wrap     (tick)
    );

    ptmr_seq #(.SEQ_W(SEQ_W)) u_seq (
        .clk  (clk),
        .srst (srst),
        .adv  (tick),
        .step (step)
    );

    // R2: a doubled-mode reload always leaves an odd count
    a_r2_odd_load: assert property (@(posedge clk) disable iff (srst)
        (tick && dbl_mode) |=> count[0]);

    // R10: leaving reset, count and step start from zero
    a_r10_reset_clear: assert property (@(posedge clk) disable iff (srst)
        $fell(srst) |-> (count == '0 && step == '0));

    // R11: a tick happens only on an enabled cycle
    a_r11_tick_enabled: assert property (@(posedge clk) disable iff (srst)
        tick |-> ce);

endmodule

// File: tb/chan_period_timer_bench.sv
module chan_period_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LO_W  = 4;
    localparam int HI_W  = 2;
    localparam int SEQ_W = 3;
    localparam int PW    = LO_W + HI_W;
    localparam int CW    = PW + 1;
    localparam int PMAX  = (1 << PW) - 1;
    localparam int SMOD  = 1 << SEQ_W;

    logic            clk = 1'b0;
    logic            srst = 1'b1;
    logic            ce = 1'b0;
    logic            dbl = 1'b0;
    logic [LO_W-1:0] lo = '0;
    logic [HI_W-1:0] hi = '0;
    logic [CW-1:0]   count;
    logic            tick;
    logic [SEQ_W-1:0] step;

    int checks = 0;
    int fails  = 0;
    int m_cnt  = 0;
    int m_seq  = 0;
    int cyc    = 0;
    int last_tick = -1;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_period_timer #(.LO_W(LO_W), .HI_W(HI_W), .SEQ_W(SEQ_W)) u_chan_period_timer (
        .clk(clk), .srst(srst), .ce(ce), .per_lo(lo), .per_hi(hi),
        .dbl_mode(dbl), .count(count), .tick(tick), .step(step)
    );

    function automatic int load_of();
        int p;
        p = int'({hi, lo});
        return dbl ? (p * 2 + 1) : p;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_period(input int p);
        {hi, lo} = PW'(p);
    endtask

    // One clock: drive ce at negedge, check outputs, then advance the model.
    task automatic cycle(input bit ce_v, input int exp_per);
        bit exp_tick;
        @(negedge clk);
        ce = ce_v;
        #1;
        exp_tick = ce_v && (m_cnt == 0);
        chk(int'(count) == m_cnt, ce_v ? "R3/R4 count" : "R12 hold count", int'(count), m_cnt);
        chk(tick == exp_tick, ce_v ? "R11 tick" : "R12 tick low", int'(tick), int'(exp_tick));
        chk(int'(step) == m_seq, "R7 step", int'(step), m_seq);
        if (tick && exp_per > 0) begin
            if (last_tick >= 0)
                chk(cyc - last_tick == exp_per, dbl ? "R5 interval" : "R6 interval",
                    cyc - last_tick, exp_per);
            last_tick = cyc;
        end
        if (ce_v) cyc++;
        @(posedge clk);
        if (ce_v) begin
            if (m_cnt == 0) begin
                m_cnt = load_of();
                m_seq = (m_seq + 1) % SMOD;
            end else begin
                m_cnt--;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        srst = 1'b1;
        ce   = 1'b0;
        @(negedge clk);
        #1;
        chk(count == '0, "R10 reset count", int'(count), 0);
        chk(step == '0, "R10 reset step", int'(step), 0);
        chk(tick == 1'b0, "R10 reset tick", int'(tick), 0);
        srst = 1'b0;
        m_cnt = 0;
        m_seq = 0;
        cyc = 0;
        last_tick = -1;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        do_reset();

        // R1 R2 R5 R6 R8: every period in both modes
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p <= PMAX; p++) begin
                int per;
                int exp_load;
                dbl = m[0];
                set_period(p);
                do_reset();
                per = dbl ? (2 * p + 2) : (p + 1);
                exp_load = dbl ? (2 * p + 1) : p;
                cycle(1'b1, per);
                #2;
                if (dbl && p == PMAX)
                    chk(int'(count) == (1 << CW) - 1, "R8 max load", int'(count), (1 << CW) - 1);
                else
                    chk(int'(count) == exp_load, dbl ? "R1/R2 load" : "R1/R6 load",
                        int'(count), exp_load);
                repeat (3 * per + 1) cycle(1'b1, per);
            end
        end

        // R9: period change mid countdown
        dbl = 1'b1;
        set_period(10);
        do_reset();
        cycle(1'b1, 0);
        repeat (5) cycle(1'b1, 0);
        set_period(3);
        repeat (16) cycle(1'b1, 0);
        #2;
        chk(int'(count) == 0, "R9 old countdown kept", int'(count), 0);
        cycle(1'b1, 0);
        #2;
        chk(int'(count) == 7, "R9 new load", int'(count), 7);
        repeat (20) cycle(1'b1, 0);

        // R12: enable gaps
        dbl = 1'b0;
        set_period(5);
        do_reset();
        for (int i = 0; i < 60; i++) cycle((i % 3) != 2, 0);

        // R7: step wraps past its top value
        set_period(0);
        do_reset();
        repeat (20) cycle(1'b1, 1);
        chk(m_seq == 20 % SMOD, "R7 wrap model", m_seq, 20 % SMOD);

        // R10: reset in the middle of a run, then immediate reload
        dbl = 1'b1;
        set_period(20);
        do_reset();
        repeat (30) cycle(1'b1, 0);
        do_reset();
        cycle(1'b1, 0);
        #2;
        chk(int'(count) == 41, "R10 first reload after reset", int'(count), 41);
        chk(int'(step) == 1, "R10 step after first reload", int'(step), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule